// File: doc/BRIEF.md
# Pass-Through Burst Write Target

This block is the receiving end of a burst write aimed at a single pass-through data register. The initiator opens a burst with an address phase. The block claims the burst only when the address decoder's hit input is high. After that, each data phase offered by the initiator places one dword into a holding register. A local add-on agent reads that register through a valid/acknowledge handshake.

The target raises ready only when the holding register has room. The register has room when it is empty, or when the add-on acknowledges the current dword in the same clock. An add-on that reads every clock therefore sustains one dword per bus clock.

While a data phase waits for room, a counter measures the stall. The first data phase of a burst may wait 16 clocks. Each later data phase may wait 8 clocks. When the limit runs out, the block asks the initiator to stop and keeps asking until the burst ends. Apart from this timeout the target never stops a burst. A burst that the initiator ends on its own completes normally.

Top module: `pt_write_target`

## Requirements
- R1: During reset and in the first clock after it, `bus_trdy`, `bus_stop` and `ao_valid` are low.
- R2: In a claimed burst, a data phase (`bus_frame`=1, `bus_irdy`=1, `bus_addr`=0) sees `bus_trdy`=1 in the same clock whenever `ao_valid`=0 or `ao_ack`=1. From the next clock, `ao_valid`=1 and `ao_data` holds the accepted dword, so the block can accept one dword per clock.
- R3: While `ao_valid`=1 and `ao_ack`=0, `bus_trdy` stays low, and `ao_valid` and `ao_data` hold their values.
- R4: If the first data phase of a burst waits without acceptance, `bus_stop` rises in its 16th consecutive waiting clock (FIRST_LIMIT) and not before. `bus_trdy` stays low in that clock.
- R5: On any later data phase of the same burst, `bus_stop` rises in the 8th consecutive waiting clock (LATER_LIMIT) and not before.
- R6: A stop does not accept the pending dword. `ao_data` keeps the unread dword and `ao_valid` stays high.
- R7: After a stop, `bus_stop` stays high and `bus_trdy` stays low while `bus_frame` is high. Both are low once `bus_frame` is low.
- R8: A new address phase with `bus_hit`=1 restores the first-phase limit of 16 clocks, even directly after a stopped burst.
- R9: The wait count starts from zero for each data phase. It clears on an accept and on an `ao_ack`, so an earlier partial wait does not shorten a later limit.
- R10: An address phase with `bus_hit`=0 is ignored. `bus_trdy` and `bus_stop` stay low for that burst, and the register is untouched.
- R11: A burst that the initiator ends by dropping `bus_frame` never produces `bus_stop`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_frame | input | 1 | High for the whole burst, including its address phase |
| bus_addr | input | 1 | Marks the address phase of a burst |
| bus_hit | input | 1 | Address decode result, sampled in the address phase |
| bus_irdy | input | 1 | Initiator offers a dword on `bus_wdata` |
| bus_wdata | input | DW | Write data |
| bus_trdy | output | 1 | Target accepts the offered dword this clock |
| bus_stop | output | 1 | Target requests a disconnect |
| ao_valid | output | 1 | Holding register contains an unread dword |
| ao_data | output | DW | Holding register contents |
| ao_ack | input | 1 | Add-on reads the holding register this clock |

## Verification
The main path is driven with three add-on patterns: an acknowledge in every clock, idle initiator clocks in the middle of a burst, and a short add-on stall that ends before the limit. These show that back-to-back acceptance works, that idle initiator clocks neither accept nor time out, and that a relieved stall resumes cleanly. The timeout is tested at its exact boundary for the first phase and for a later phase. Further cases cover a stall preceded by a partial wait, a new burst right after a stopped one, an unclaimed burst, and a burst the initiator ends on its own. Together these separate a wrong limit, a counter that is never cleared, and a stop that leaks out of its burst.

// File: rtl/pt_write_target.sv
module pt_write_target #(
  parameter int DW          = 32,
  parameter int FIRST_LIMIT = 16,
  parameter int LATER_LIMIT = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_frame,
  input  logic          bus_addr,
  input  logic          bus_hit,
  input  logic          bus_irdy,
  input  logic [DW-1:0] bus_wdata,
  output logic          bus_trdy,
  output logic          bus_stop,
  output logic          ao_valid,
  output logic [DW-1:0] ao_data,
  input  logic          ao_ack
);
  localparam int MAXL = (FIRST_LIMIT > LATER_LIMIT) ? FIRST_LIMIT : LATER_LIMIT;
  localparam int CW   = $clog2(MAXL + 1);

  typedef enum logic [1:0] {S_IDLE, S_CLAIM, S_HALT} st_t;

  st_t           st_q;
  logic          first_q;
  logic [CW-1:0] wait_q;

  logic          claim, pend, room, timeout;
  logic [CW-1:0] lim_m1;

  assign claim   = bus_frame && bus_addr && bus_hit;
  assign pend    = (st_q == S_CLAIM) && bus_frame && !bus_addr && bus_irdy;
  assign room    = !ao_valid || ao_ack;
  assign lim_m1  = first_q ? CW'(FIRST_LIMIT - 1) : CW'(LATER_LIMIT - 1);
  assign timeout = pend && !room && (wait_q == lim_m1);

  assign bus_trdy = pend && room;
  assign bus_stop = timeout || ((st_q == S_HALT) && bus_frame);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      first_q <= 1'b1;
      wait_q  <= '0;
    end else begin
      if (claim)           st_q <= S_CLAIM;
      else if (!bus_frame) st_q <= S_IDLE;
      else if (timeout)    st_q <= S_HALT;

      if (claim)         first_q <= 1'b1;
      else if (bus_trdy) first_q <= 1'b0;

      if (claim || bus_trdy || ao_ack || timeout) wait_q <= '0;
      else if (pend)                              wait_q <= wait_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ao_valid <= 1'b0;
      ao_data  <= '0;
    end else if (bus_trdy) begin
      ao_valid <= 1'b1;
      ao_data  <= bus_wdata;
    end else if (ao_ack) begin
      ao_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/pt_write_target_chk.sv
module pt_write_target_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_frame,
  input logic          bus_addr,
  input logic          bus_irdy,
  input logic [DW-1:0] bus_wdata,
  input logic          bus_trdy,
  input logic          bus_stop,
  input logic          ao_valid,
  input logic [DW-1:0] ao_data,
  input logic          ao_ack
);
  AST_TRDY_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    bus_trdy |-> (!ao_valid || ao_ack));                                // R2
  AST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_trdy |=> (ao_valid && ao_data == $past(bus_wdata)));            // R2
  AST_HOLD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (ao_valid && !ao_ack) |=> ao_valid);                                // R3
  AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (ao_valid && !bus_trdy) |=> $stable(ao_data));                      // R6
  AST_STOP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    bus_stop |-> !bus_trdy);                                            // R7
  AST_STOP_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    bus_stop |-> bus_frame);                                            // R11
  AST_TRDY_IRDY: assert property (@(posedge clk) disable iff (!rst_n)
    bus_trdy |-> (bus_irdy && bus_frame && !bus_addr));                 // R10
endmodule

bind pt_write_target pt_write_target_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_frame(bus_frame), .bus_addr(bus_addr),
  .bus_irdy(bus_irdy), .bus_wdata(bus_wdata), .bus_trdy(bus_trdy),
  .bus_stop(bus_stop), .ao_valid(ao_valid), .ao_data(ao_data), .ao_ack(ao_ack)
);

// File: tb/pt_write_target_tb.sv
module pt_write_target_tb;
  localparam int DW = 32;
  logic clk = 1'b0, rst_n = 1'b0;
  logic frame = 0, addr = 0, hit = 0, irdy = 0, ack = 0;
  logic [DW-1:0] wdata = '0;
  logic trdy, stop, valid;
  logic [DW-1:0] data;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  pt_write_target #(.DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_frame(frame), .bus_addr(addr), .bus_hit(hit),
    .bus_irdy(irdy), .bus_wdata(wdata), .bus_trdy(trdy), .bus_stop(stop),
    .ao_valid(valid), .ao_data(data), .ao_ack(ack));

  // {frame,addr,hit,irdy,ack, wdata[7:0], trdy,stop,valid, data[7:0]}
  localparam int NV = 13;
  localparam logic [23:0] VEC [NV] = '{
    {5'b00000, 8'h00, 3'b000, 8'h00},
    {5'b11100, 8'h00, 3'b000, 8'h00},
    {5'b10010, 8'h11, 3'b100, 8'h00},
    {5'b10011, 8'h22, 3'b101, 8'h11},
    {5'b10011, 8'h33, 3'b101, 8'h22},
    {5'b10000, 8'h00, 3'b001, 8'h33},
    {5'b10010, 8'h44, 3'b001, 8'h33},
    {5'b10011, 8'h44, 3'b101, 8'h33},
    {5'b00001, 8'h00, 3'b001, 8'h44},
    {5'b00000, 8'h00, 3'b000, 8'h44},
    {5'b11000, 8'h00, 3'b000, 8'h44},
    {5'b10010, 8'h55, 3'b000, 8'h44},
    {5'b00000, 8'h00, 3'b000, 8'h44}
  };

  task automatic chk(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic cyc(input logic f, input logic a, input logic h, input logic i,
                     input logic k, input logic [DW-1:0] d);
    @(negedge clk);
    frame = f; addr = a; hit = h; irdy = i; ack = k; wdata = d;
    #2;
  endtask

  task automatic outs(input string req, input logic t, input logic s, input logic v);
    chk({req, " trdy"}, DW'(trdy), DW'(t));
    chk({req, " stop"}, DW'(stop), DW'(s));
    chk({req, " valid"}, DW'(valid), DW'(v));
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset
    cyc(0, 0, 0, 0, 0, '0);
    outs("R1 in reset", 0, 0, 0);
    cyc(0, 0, 0, 0, 0, '0);
    rst_n = 1'b1;
    cyc(0, 0, 0, 0, 0, '0);
    outs("R1 after reset", 0, 0, 0);

    // R2/R3/R10/R11 vector walk
    for (int n = 0; n < NV; n++) begin
      logic [23:0] v;
      v = VEC[n];
      cyc(v[23], v[22], v[21], v[20], v[19], DW'(v[18:11]));
      outs("R2/R3/R10/R11 vector", v[10], v[9], v[8]);
      chk("R3 vector data", data, DW'(v[7:0]));
    end

    // R4/R6: leave A1 unread, then first phase of new burst waits 16
    cyc(1, 1, 1, 0, 0, '0);
    cyc(1, 0, 0, 1, 0, 32'hA1);
    chk("R2 accept A1", DW'(trdy), 1);
    cyc(0, 0, 0, 0, 0, '0);
    cyc(1, 1, 1, 0, 0, '0);
    for (int k = 1; k <= 16; k++) begin
      cyc(1, 0, 0, 1, 0, 32'hB1);
      outs("R4 first phase wait", 0, k == 16, 1);
    end
    cyc(1, 0, 0, 1, 0, 32'hB1);
    outs("R7 stop held", 0, 1, 1);
    chk("R6 data kept", data, 32'hA1);
    cyc(0, 0, 0, 0, 0, '0);
    outs("R7 frame low", 0, 0, 1);
    chk("R6 data kept after burst", data, 32'hA1);

    // R5: drain, then second phase waits 8
    cyc(0, 0, 0, 0, 1, '0);
    cyc(1, 1, 1, 0, 0, '0);
    cyc(1, 0, 0, 1, 0, 32'hC1);
    chk("R5 accept C1", DW'(trdy), 1);
    for (int k = 1; k <= 8; k++) begin
      cyc(1, 0, 0, 1, 0, 32'hC2);
      outs("R5 later phase wait", 0, k == 8, 1);
    end
    chk("R6 C1 kept", data, 32'hC1);

    // R8: new burst right after stop, register still full -> 16 again
    cyc(0, 0, 0, 0, 0, '0);
    cyc(1, 1, 1, 0, 0, '0);
    for (int k = 1; k <= 16; k++) begin
      cyc(1, 0, 0, 1, 0, 32'hD1);
      outs("R8 first-phase limit restored", 0, k == 16, 1);
    end
    cyc(0, 0, 0, 0, 0, '0);

    // R9: partial wait of 5, ack, then a fresh 8-clock wait
    cyc(1, 1, 1, 0, 0, '0);
    for (int k = 1; k <= 5; k++) begin
      cyc(1, 0, 0, 1, 0, 32'hE1);
      outs("R9 partial wait", 0, 0, 1);
    end
    cyc(1, 0, 0, 1, 1, 32'hE1);
    outs("R9 released by ack", 1, 0, 1);
    cyc(1, 0, 0, 1, 0, 32'hE2);
    outs("R9 first phase done", 0, 0, 1);
    chk("R9 data E1", data, 32'hE1);
    cyc(1, 0, 0, 1, 1, 32'hE2);
    outs("R9 accept E2", 1, 0, 1);
    for (int k = 1; k <= 8; k++) begin
      cyc(1, 0, 0, 1, 0, 32'hE3);
      outs("R9 fresh later wait", 0, k == 8, 1);
    end
    cyc(0, 0, 0, 0, 0, '0);
    outs("R11 idle after burst", 0, 0, 1);
    chk("R6 data E2", data, 32'hE2);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule